// File: doc/BRIEF.md
# Gamma Ramp Lookup Table

This block is the final colour stage ahead of the video output. It keeps a separate 256-entry correction table for each of the red, green and blue channels. Each table maps an 8-bit channel value to its corrected 8-bit value, which compensates for the non-linear response of the monitor. While pixels stream through, each channel value is replaced by its table entry.

A host fills the tables through two write strobes. It first presets the table pointer, normally to zero. It then sends one 32-bit word per table index, and each word carries all three channel values for that index. The pointer advances by one after each word, so a full ramp of 256 words follows a single pointer preset. The pointer wraps back to entry 0 after entry 255.

Top module: `gamma_lut`

## Requirements
- R1: After a synchronous active-low reset, `pix_valid_o` is 0, `pix_r_o`, `pix_g_o` and `pix_b_o` are 0, and the table pointer is 0. A triple written after reset with no pointer preset therefore lands in entry 0.
- R2: A cycle with `ptr_we` high loads the table pointer from `ptr_wdata`. The next triple write goes to that entry.
- R3: A triple word places red in bits 31:24, green in bits 23:16 and blue in bits 15:8. Each byte is stored in its own channel's table.
- R4: Bits 7:0 of a triple word are ignored. The bench loads every entry with a nonzero low byte, and the stored values must still match bits 31:8 exactly.
- R5: Each triple write (`rgb_we` high) advances the pointer by one, unless `ptr_we` is also high in that cycle.
- R6: Advancing the pointer past entry 255 wraps it to entry 0.
- R7: A pixel presented with `pix_valid_i` high appears corrected on the outputs one clock later, with `pix_valid_o` high in that cycle. `pix_valid_o` equals `pix_valid_i` delayed by one cycle.
- R8: Each channel is looked up independently, using its own input value as the index into its own table.
- R9: A triple write and a display read of the same entry in the same cycle: the write completes, and the read returns the entry's previous contents.
- R10: When `ptr_we` and `rgb_we` are both high, the triple is written at the old pointer value, and the pointer then takes `ptr_wdata`.
- R11: While `pix_valid_i` is low, the colour outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_we | input | 1 | Load strobe for the table pointer |
| ptr_wdata | input | 8 | New table pointer value |
| rgb_we | input | 1 | Triple write strobe |
| rgb_wdata | input | 32 | Packed triple: red 31:24, green 23:16, blue 15:8, bits 7:0 unused |
| pix_valid_i | input | 1 | Incoming pixel qualifier |
| pix_r_i | input | 8 | Incoming red value |
| pix_g_i | input | 8 | Incoming green value |
| pix_b_i | input | 8 | Incoming blue value |
| pix_valid_o | output | 1 | Corrected pixel qualifier, one cycle after the input |
| pix_r_o | output | 8 | Corrected red value |
| pix_g_o | output | 8 | Corrected green value |
| pix_b_o | output | 8 | Corrected blue value |

## Verification
The assertions assume that the strobes and the pixel qualifier are driven to known levels in every cycle after reset. They also assume that the pointer moves only through the two write strobes. The properties on the table contents compare against the pointer as it stood in the previous cycle, so they also assume the strobes are synchronous to `clk`. The stimulus meets these assumptions: every input is held at a defined value from time zero, and every input changes only on the falling edge. The bench loads the whole table before it reads any entry, so no check depends on the unreset memory contents.

// File: rtl/gamma_lut_pkg.sv
// Package: shared widths and the channel enumeration for the gamma lookup.
// Assumes three colour channels, ordered red, green, blue from the top of a triple word.
package gamma_lut_pkg;
    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;
endpackage

// File: rtl/gamma_ptr_ctl.sv
// Module: table pointer with preset and auto-advance.
// Assumes a preset takes priority over the advance when both strobes arrive in one cycle.
module gamma_ptr_ctl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we,
    input  logic [AW-1:0] ptr_wdata,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    // Pointer register: reset to zero, load on preset, otherwise step by one modulo the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_we) begin
            ptr <= ptr_wdata;
        end else if (adv) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/gamma_tri_unpack.sv
// Module: splits the used upper part of a triple word into per-channel bytes.
// Assumes channel k sits k byte-lanes below the top of the word; the lowest lane is not passed in.
module gamma_tri_unpack #(
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input  logic [NCH*DW-1:0]        word_hi,
    output logic [NCH-1:0][DW-1:0]   chan
);
    localparam int TOP = NCH * DW;

    // One slice per channel, taken from the top of the word downwards.
    for (genvar k = 0; k < NCH; k++) begin : g_slice
        assign chan[k] = word_hi[TOP-1-k*DW -: DW];
    end
endmodule

// File: rtl/gamma_chan_ram.sv
// Module: one channel's correction table with a registered read port.
// Assumes the same-cycle write and read of one entry returns the old contents.
// The read register holds while no read is requested.
module gamma_chan_ram #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Table storage: written on the host strobe, with no reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read register: reset to zero, updated only for a valid pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/gamma_lut.sv
// Module: three-channel gamma correction table with a host load path.
// Assumes a host presets the pointer and then streams packed triples.
// Pixels are corrected with one cycle of latency.
module gamma_lut #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ptr_we,
    input  logic [AW-1:0]   ptr_wdata,
    input  logic            rgb_we,
    input  logic [4*DW-1:0] rgb_wdata,
    input  logic            pix_valid_i,
    input  logic [DW-1:0]   pix_r_i,
    input  logic [DW-1:0]   pix_g_i,
    input  logic [DW-1:0]   pix_b_i,
    output logic            pix_valid_o,
    output logic [DW-1:0]   pix_r_o,
    output logic [DW-1:0]   pix_g_o,
    output logic [DW-1:0]   pix_b_o
);
    import gamma_lut_pkg::*;

    localparam int WW = 4 * DW;

    logic [AW-1:0]              wr_ptr;
    logic [NUM_CH-1:0][DW-1:0]  wr_chan;
    logic [NUM_CH-1:0][DW-1:0]  rd_idx;
    logic [NUM_CH-1:0][DW-1:0]  rd_val;
    logic                       unused_low;

    // The low byte of a triple carries nothing.
    assign unused_low = ^rgb_wdata[DW-1:0];

    // Route each pixel channel to the index of its own table.
    assign rd_idx[CH_RED]   = pix_r_i;
    assign rd_idx[CH_GREEN] = pix_g_i;
    assign rd_idx[CH_BLUE]  = pix_b_i;

    gamma_ptr_ctl #(.AW(AW)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .adv       (rgb_we),
        .ptr       (wr_ptr)
    );

    gamma_tri_unpack #(.DW(DW), .NCH(NUM_CH)) i_unpack (
        .word_hi (rgb_wdata[WW-1:DW]),
        .chan    (wr_chan)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        gamma_chan_ram #(.DW(DW), .AW(AW)) i_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (rgb_we),
            .waddr (wr_ptr),
            .wdata (wr_chan[k]),
            .re    (pix_valid_i),
            .raddr (rd_idx[k][AW-1:0]),
            .rdata (rd_val[k])
        );
    end

    // Delay the pixel qualifier to line up with the registered table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid_o <= 1'b0;
        end else begin
            pix_valid_o <= pix_valid_i;
        end
    end

    assign pix_r_o = rd_val[CH_RED];
    assign pix_g_o = rd_val[CH_GREEN];
    assign pix_b_o = rd_val[CH_BLUE];
endmodule

// File: rtl/gamma_lut_chk.sv
// Checker: temporal properties of the pointer and the pixel pipeline of gamma_lut.
// Assumes synchronous strobes and known input levels after reset.
module gamma_lut_chk #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ptr_we,
    input logic [AW-1:0] ptr_wdata,
    input logic          rgb_we,
    input logic [AW-1:0] wr_ptr,
    input logic          pix_valid_i,
    input logic          pix_valid_o,
    input logic [DW-1:0] pix_r_o,
    input logic [DW-1:0] pix_g_o,
    input logic [DW-1:0] pix_b_o
);
    // R2: a preset lands in the pointer on the next cycle.
    a_r2_preset_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (wr_ptr == $past(ptr_wdata)));

    // R5 and R6: a triple write alone steps the pointer by one, modulo the depth.
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_we && !ptr_we) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    // R5: with no strobe, the pointer holds.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rgb_we && !ptr_we) |=> $stable(wr_ptr));

    // R7: a valid pixel yields a valid output one cycle later.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o);

    // R7: no valid pixel, no valid output.
    a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o);

    // R11: the colour outputs hold while no pixel is presented.
    a_r11_hold_colour: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> ($stable(pix_r_o) && $stable(pix_g_o) && $stable(pix_b_o)));
endmodule

bind gamma_lut gamma_lut_chk #(.DW(DW), .AW(AW)) i_gamma_lut_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr_we      (ptr_we),
    .ptr_wdata   (ptr_wdata),
    .rgb_we      (rgb_we),
    .wr_ptr      (wr_ptr),
    .pix_valid_i (pix_valid_i),
    .pix_valid_o (pix_valid_o),
    .pix_r_o     (pix_r_o),
    .pix_g_o     (pix_g_o),
    .pix_b_o     (pix_b_o)
);

// File: tb/test_gamma_lut.sv
// Bench: loads a computed ramp, walks a vector table of pixels, then runs directed corner tests.
module test_gamma_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_we = 1'b0;
    logic [7:0]  ptr_wdata = '0;
    logic        rgb_we = 1'b0;
    logic [31:0] rgb_wdata = '0;
    logic        pix_valid_i = 1'b0;
    logic [7:0]  pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
    logic        pix_valid_o;
    logic [7:0]  pix_r_o, pix_g_o, pix_b_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gamma_lut i_gamma_lut (
        .clk(clk), .rst_n(rst_n),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .rgb_we(rgb_we), .rgb_wdata(rgb_wdata),
        .pix_valid_i(pix_valid_i), .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
        .pix_valid_o(pix_valid_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
    );

    // Expected ramp: a distinct function per channel.
    function automatic logic [7:0] gam(int ch, int i);
        return 8'((i * (ch * 2 + 3)) + ch * 41 + 7);
    endfunction

    localparam logic [23:0] VEC [12] = '{
        24'h000000, 24'hFFFFFF, 24'h80407F, 24'h01FE02, 24'h10203F, 24'hAA5533,
        24'h7F8081, 24'hFE0001, 24'h3C3C3C, 24'hC0D0E0, 24'h05FA11, 24'h99EE44
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_ptr(logic [7:0] a);
        ptr_we = 1'b1; ptr_wdata = a;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic put_rgb(logic [31:0] w);
        rgb_we = 1'b1; rgb_wdata = w;
        @(negedge clk);
        rgb_we = 1'b0;
    endtask

    // Present one pixel, then check the outputs one cycle later.
    task automatic look(string req, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                        logic [23:0] exp);
        pix_valid_i = 1'b1; pix_r_i = r; pix_g_i = g; pix_b_i = b;
        @(negedge clk);
        pix_valid_i = 1'b0;
        chk(req, {pix_r_o, pix_g_o, pix_b_o}, {8'h0, exp});
        chk(req, {31'h0, pix_valid_o}, 32'h1);
    endtask

    function automatic logic [31:0] ramp_word(int i);
        return {gam(0, i), gam(1, i), gam(2, i), 8'hA5};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs.
        chk("R1 valid", {31'h0, pix_valid_o}, 32'h0);
        chk("R1 colour", {8'h0, pix_r_o, pix_g_o, pix_b_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: the pointer starts at entry 0.
        put_rgb(32'h11223300);
        look("R1 pointer zero", 8'h00, 8'h00, 8'h00, 24'h112233);

        // R2, R3, R4: preset to 0 and load the full ramp, with a junk low byte.
        put_ptr(8'h00);
        for (int i = 0; i < 256; i++) put_rgb(ramp_word(i));
        // R6: the pointer has wrapped to 0, so this lands in entry 0.
        put_rgb(32'h9A8B7CFF);
        look("R6 wrap", 8'h00, 8'h00, 8'h00, 24'h9A8B7C);
        // R5: the following write lands in entry 1.
        put_rgb(32'h01020300);
        look("R5 increment", 8'h01, 8'h01, 8'h01, 24'h010203);
        put_ptr(8'h00);
        put_rgb(ramp_word(0));
        put_rgb(ramp_word(1));

        // R3, R4, R7, R8: stream the vector table back to back.
        for (int v = 0; v < 12; v++) begin
            pix_valid_i = 1'b1;
            pix_r_i = VEC[v][23:16]; pix_g_i = VEC[v][15:8]; pix_b_i = VEC[v][7:0];
            @(negedge clk);
            chk("R8 red",   {24'h0, pix_r_o}, {24'h0, gam(0, int'(VEC[v][23:16]))});
            chk("R8 green", {24'h0, pix_g_o}, {24'h0, gam(1, int'(VEC[v][15:8]))});
            chk("R3 blue",  {24'h0, pix_b_o}, {24'h0, gam(2, int'(VEC[v][7:0]))});
            chk("R7 valid", {31'h0, pix_valid_o}, 32'h1);
        end
        pix_valid_i = 1'b0;
        pix_r_i = 8'h33; pix_g_i = 8'h44; pix_b_i = 8'h55;
        @(negedge clk);
        // R7: the qualifier drops one cycle after the input drops.
        chk("R7 drop", {31'h0, pix_valid_o}, 32'h0);
        @(negedge clk);
        // R11: the last colour is held.
        chk("R11 hold", {8'h0, pix_r_o, pix_g_o, pix_b_o},
            {8'h0, gam(0, 16'h99), gam(1, 16'hEE), gam(2, 16'h44)});

        // R9: write and read entry 5 in the same cycle.
        put_ptr(8'h05);
        rgb_we = 1'b1; rgb_wdata = 32'hC1C2C300;
        pix_valid_i = 1'b1; pix_r_i = 8'h05; pix_g_i = 8'h05; pix_b_i = 8'h05;
        @(negedge clk);
        rgb_we = 1'b0; pix_valid_i = 1'b0;
        chk("R9 old value", {8'h0, pix_r_o, pix_g_o, pix_b_o},
            {8'h0, gam(0, 5), gam(1, 5), gam(2, 5)});
        look("R9 write done", 8'h05, 8'h05, 8'h05, 24'hC1C2C3);

        // R10: a preset and a triple write together.
        put_ptr(8'd20);
        ptr_we = 1'b1; ptr_wdata = 8'd40;
        rgb_we = 1'b1; rgb_wdata = 32'hD1D2D300;
        @(negedge clk);
        ptr_we = 1'b0; rgb_we = 1'b0;
        put_rgb(32'hE1E2E300);
        look("R10 old pointer", 8'd20, 8'd20, 8'd20, 24'hD1D2D3);
        look("R10 new pointer", 8'd40, 8'd40, 8'd40, 24'hE1E2E3);
        // R2: a preset to the top entry, then a write there.
        put_ptr(8'hFF);
        put_rgb(32'h0A0B0C77);
        look("R2 preset top", 8'hFF, 8'hFF, 8'hFF, 24'h0A0B0C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule